// File: doc/BRIEF.md
# Display Shift Address Mapper

This block turns a character cell on a dot-matrix display into the address of the display data RAM location that holds its character code. The cell is given as a 1-based position index and a line select. The block keeps a shift offset that moves the whole picture by one cell for each left-shift or right-shift strobe. Each line owns a 40-entry RAM region: line 1 starts at 00h and line 2 starts at 40h. The shifted index wraps around inside its own region, so a cell never picks up an address from the other line or from the unused gap between the regions.

The block has two addressing modes. In dual-line mode the line select chooses the region. In split mode one physical 16-cell row is addressed as two logical lines. The left half, positions 1 to 8, reads from the line-1 region. The right half, positions 9 to 16, reads from the line-2 region, starting again at the region base. The same shift offset applies to both halves.

The offset is registered. The address is computed combinationally from the offset and the current inputs. Positions beyond the visible width are flagged as not valid.

Top module: `disp_addr_map`

## Requirements
- R1: After reset the offset is zero. In dual-line mode, position p on line 1 (lineSel=0) gives address p-1, and on line 2 (lineSel=1) gives 40h+p-1.
- R2: Each clock edge with shiftLeft=1 and shiftRight=0 advances the offset by one, modulo 40. After one left shift, position 1 of line 1 gives 01h and position 40 gives 00h.
- R3: Each clock edge with shiftRight=1 and shiftLeft=0 moves the offset back by one, modulo 40. From zero offset, one right shift makes position 1 give 27h and position 2 give 00h.
- R4: One offset serves both lines. With offset 39, line 2 position 1 gives 67h and position 2 gives 40h.
- R5: A clock edge with both strobes high, or with both low, leaves the offset unchanged.
- R6: In split mode (splitMode=1), position p in 1..8 gives ((p-1+offset) mod 40), and p in 9..16 gives 40h+((p-9+offset) mod 40). Each half wraps inside its own region.
- R7: In split mode, lineSel has no effect on the address.
- R8: addrValid is 1 only when the position is in 1..40 in dual-line mode, or in 1..16 in split mode. When addrValid is 0, ramAddr is 00h.
- R9: ramAddr follows the position, line and mode inputs in the same cycle. A shift strobe affects ramAddr only after the clock edge that samples it.
- R10: Forty left shifts in a row bring the offset back to zero. Offset 39 followed by a left shift gives offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, clears the offset |
| shiftLeft | input | 1 | Left-shift strobe, one cell per sampled cycle |
| shiftRight | input | 1 | Right-shift strobe, one cell per sampled cycle |
| splitMode | input | 1 | 1: single row split into two logical lines |
| lineSel | input | 1 | Line select in dual-line mode (0 = line 1) |
| position | input | 6 | 1-based display position |
| ramAddr | output | 7 | Display data RAM address |
| addrValid | output | 1 | Position lies inside the visible width |

## Verification
The address path is combinational. The bench therefore drives position, line and mode on the falling edge and compares ramAddr and addrValid about 1 ns later, within the same cycle. The offset responds to a strobe one register later. The bench's integer model updates its own offset on the rising edge that samples the strobe. It compares during the low phase while the strobe is still applied, which confirms that the old offset is still in use. It compares again in the next cycle, where the new offset must appear. Every stepped cycle is compared against the model, including the wrap from 39 back to 0, the wrap from 0 to 39, and positions outside the visible width.

// File: rtl/shiftmap_pkg.sv
package shiftmap_pkg;
  localparam int LINE_LEN   = 40;
  localparam int LINE2_BASE = 64;
  localparam int ADDR_W     = 7;
  localparam int POS_W      = 6;

  typedef struct packed {
    logic incOfs;
    logic decOfs;
  } ofsCtl_t;
endpackage

// File: rtl/shift_ctrl.sv
module shift_ctrl
  import shiftmap_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    shiftLeft,
  input  logic    shiftRight,
  output ofsCtl_t ctl
);
  always_comb begin
    ctl.incOfs = shiftLeft & ~shiftRight;
    ctl.decOfs = shiftRight & ~shiftLeft;
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl.incOfs && ctl.decOfs)); // R5
  AST_BOTH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (shiftLeft && shiftRight) |-> (!ctl.incOfs && !ctl.decOfs)); // R5
endmodule

// File: rtl/shift_dp.sv
module shift_dp
  import shiftmap_pkg::*;
#(
  parameter int LEN      = LINE_LEN,
  parameter int BASE2    = LINE2_BASE,
  parameter int AW       = ADDR_W,
  parameter int PW       = POS_W,
  parameter int VIS_POS  = 40,
  parameter int SPLIT_ROW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ofsCtl_t       ctl,
  input  logic          splitMode,
  input  logic          lineSel,
  input  logic [PW-1:0] position,
  output logic [AW-1:0] ramAddr,
  output logic          addrValid
);
  localparam int OFS_W = $clog2(LEN);
  localparam int HALF  = SPLIT_ROW / 2;
  localparam logic [OFS_W-1:0] OFS_LAST = OFS_W'(LEN - 1);
  localparam logic [PW:0]      LEN_X    = (PW+1)'(LEN);
  localparam logic [PW-1:0]    HALF_P   = PW'(HALF);
  localparam logic [PW-1:0]    VIS_P    = PW'(VIS_POS);
  localparam logic [PW-1:0]    ROW_P    = PW'(SPLIT_ROW);
  localparam logic [AW-1:0]    BASE2_A  = AW'(BASE2);
  localparam logic [AW-1:0]    LEN_A    = AW'(LEN);
  localparam logic [AW-1:0]    END2_A   = AW'(BASE2 + LEN);

  logic [OFS_W-1:0] ofsQ;
  logic [PW-1:0]    relPos;
  logic [PW:0]      sumIdx;
  logic [PW:0]      wrapIdx;
  logic             useLine2;
  logic [PW-1:0]    limit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ofsQ <= '0;
    end else if (ctl.incOfs) begin
      ofsQ <= (ofsQ == OFS_LAST) ? '0 : ofsQ + 1'b1;
    end else if (ctl.decOfs) begin
      ofsQ <= (ofsQ == '0) ? OFS_LAST : ofsQ - 1'b1;
    end
  end

  always_comb begin
    limit     = splitMode ? ROW_P : VIS_P;
    addrValid = (position != '0) && (position <= limit);
    if (splitMode) begin
      useLine2 = position > HALF_P;
      relPos   = useLine2 ? position - HALF_P - 1'b1 : position - 1'b1;
    end else begin
      useLine2 = lineSel;
      relPos   = position - 1'b1;
    end
    sumIdx  = {1'b0, relPos} + (PW+1)'(ofsQ);
    wrapIdx = (sumIdx >= LEN_X) ? sumIdx - LEN_X : sumIdx;
    if (addrValid)
      ramAddr = (useLine2 ? BASE2_A : '0) + AW'(wrapIdx);
    else
      ramAddr = '0;
  end

  AST_OFS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ofsQ <= OFS_LAST); // R2
  AST_LEFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.incOfs |=> ofsQ == (($past(ofsQ) == OFS_LAST) ? '0 : $past(ofsQ) + 1'b1)); // R10
  AST_RIGHT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.decOfs |=> ofsQ == (($past(ofsQ) == '0) ? OFS_LAST : $past(ofsQ) - 1'b1)); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.incOfs && !ctl.decOfs) |=> $stable(ofsQ)); // R5
  AST_ADDR_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    addrValid |-> (ramAddr < LEN_A) || (ramAddr >= BASE2_A && ramAddr < END2_A)); // R4
  AST_INVALID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !addrValid |-> ramAddr == '0); // R8
endmodule

// File: rtl/disp_addr_map.sv
module disp_addr_map
  import shiftmap_pkg::*;
#(
  parameter int VIS_POS   = 40,
  parameter int SPLIT_ROW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shiftLeft,
  input  logic              shiftRight,
  input  logic              splitMode,
  input  logic              lineSel,
  input  logic [POS_W-1:0]  position,
  output logic [ADDR_W-1:0] ramAddr,
  output logic              addrValid
);
  ofsCtl_t ctl;

  shift_ctrl i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .shiftLeft  (shiftLeft),
    .shiftRight (shiftRight),
    .ctl        (ctl)
  );

  shift_dp #(
    .LEN       (LINE_LEN),
    .BASE2     (LINE2_BASE),
    .AW        (ADDR_W),
    .PW        (POS_W),
    .VIS_POS   (VIS_POS),
    .SPLIT_ROW (SPLIT_ROW)
  ) i_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl       (ctl),
    .splitMode (splitMode),
    .lineSel   (lineSel),
    .position  (position),
    .ramAddr   (ramAddr),
    .addrValid (addrValid)
  );
endmodule

// File: tb/test_disp_addr_map.sv
`timescale 1ns/1ps
module test_disp_addr_map;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic shiftLeft = 1'b0, shiftRight = 1'b0, splitMode = 1'b0, lineSel = 1'b0;
  logic [5:0] position = 6'd1;
  logic [6:0] ramAddr;
  logic addrValid;
  int errors = 0;
  int checks = 0;
  int mOfs = 0;

  always #2 clk = ~clk;

  disp_addr_map i_disp_addr_map (
    .clk(clk), .rst_n(rst_n), .shiftLeft(shiftLeft), .shiftRight(shiftRight),
    .splitMode(splitMode), .lineSel(lineSel), .position(position),
    .ramAddr(ramAddr), .addrValid(addrValid)
  );

  always @(posedge clk) begin
    if (!rst_n) mOfs <= 0;
    else if (shiftLeft && !shiftRight) mOfs <= (mOfs + 1) % 40;
    else if (shiftRight && !shiftLeft) mOfs <= (mOfs + 39) % 40;
  end

  function automatic int expAddr(int ofs, bit split, bit line, int pos);
    int lim = split ? 16 : 40;
    if (pos < 1 || pos > lim) return -1;
    if (split) begin
      if (pos > 8) return 64 + (pos - 9 + ofs) % 40;
      return (pos - 1 + ofs) % 40;
    end
    return (line ? 64 : 0) + (pos - 1 + ofs) % 40;
  endfunction

  task automatic compare(string req);
    int e = expAddr(mOfs, splitMode, lineSel, int'(position));
    bit eValid = (e >= 0);
    int eAddr = eValid ? e : 0;
    checks++;
    if (addrValid !== eValid || int'(ramAddr) !== eAddr) begin
      errors++;
      $display("FAIL %s: pos=%0d split=%0d line=%0d ofs=%0d actual addr=%h valid=%0d expected addr=%h valid=%0d",
               req, position, splitMode, lineSel, mOfs, ramAddr, addrValid, eAddr, eValid);
    end
  endtask

  // drive on falling edge, compare 1 ns later, then let the rising edge pass
  task automatic step(bit l, bit r, bit sp, bit ln, int pos, string req);
    @(negedge clk);
    shiftLeft = l; shiftRight = r; splitMode = sp; lineSel = ln;
    position = 6'(pos);
    #1 compare(req);
  endtask

  task automatic expectFixed(bit sp, bit ln, int pos, int addr, string req);
    step(0, 0, sp, ln, pos, req);
    checks++;
    if (int'(ramAddr) !== addr) begin
      errors++;
      $display("FAIL %s: fixed point pos=%0d actual=%h expected=%h", req, pos, ramAddr, addr);
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state, both lines
    expectFixed(0, 0, 1, 'h00, "R1");
    expectFixed(0, 1, 1, 'h40, "R1");
    for (int p = 1; p <= 40; p++) step(0, 0, 0, 0, p, "R1");
    for (int p = 1; p <= 40; p++) step(0, 0, 0, 1, p, "R1");
    // R9 strobe applied: old offset still seen before the edge
    step(1, 0, 0, 0, 1, "R9");
    expectFixed(0, 0, 1, 'h01, "R2");
    expectFixed(0, 0, 40, 'h00, "R2");
    step(0, 1, 0, 0, 2, "R9");
    step(0, 1, 0, 0, 2, "R3");
    expectFixed(0, 0, 1, 'h27, "R3");
    expectFixed(0, 0, 2, 'h00, "R3");
    expectFixed(0, 1, 1, 'h67, "R4");
    expectFixed(0, 1, 2, 'h40, "R4");
    // R5 both strobes: no change
    step(1, 1, 0, 0, 1, "R5");
    step(1, 1, 0, 1, 5, "R5");
    expectFixed(0, 0, 1, 'h27, "R5");
    for (int p = 1; p <= 40; p += 3) step(0, 0, 0, 1, p, "R4");
    // R6 / R7 split mode at offset 39
    expectFixed(1, 0, 1, 'h27, "R6");
    expectFixed(1, 0, 9, 'h67, "R6");
    for (int p = 1; p <= 16; p++) begin
      step(0, 0, 1, 0, p, "R6");
      step(0, 0, 1, 1, p, "R7");
    end
    // R10 wrap 39 -> 0 by a left shift
    step(1, 0, 1, 1, 9, "R10");
    expectFixed(1, 1, 9, 'h40, "R7");
    expectFixed(1, 0, 8, 'h07, "R6");
    step(1, 0, 1, 0, 16, "R6");
    expectFixed(1, 0, 8, 'h08, "R6");
    expectFixed(1, 1, 16, 'h48, "R6");
    // R8 out of range
    step(0, 0, 0, 0, 0, "R8");
    step(0, 0, 0, 1, 41, "R8");
    step(0, 0, 0, 0, 63, "R8");
    step(0, 0, 1, 0, 17, "R8");
    step(0, 0, 1, 1, 0, "R8");
    step(0, 0, 1, 0, 40, "R8");
    // R10 forty lefts from offset 1 return to offset 1
    for (int k = 0; k < 40; k++) step(1, 0, 0, k[0], 1 + k, "R10");
    expectFixed(0, 0, 1, 'h01, "R10");
    // R3 forty rights with varying inputs
    for (int k = 0; k < 40; k++) step(0, 1, k[1], k[0], 40 - k, "R3");
    expectFixed(0, 1, 40, 'h40, "R3");
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule